// File: doc/BRIEF.md
# Late-Write Flow-Through Burst SRAM

This block is a cycle-level model of a synchronous static memory with a flow-through read path and a late-write data phase. A command is captured on a rising clock edge together with its address and byte mask. A read returns its word during the clock cycle that follows that edge. A write takes its data one edge later. Because the read latency and the write-data latency are both one cycle, any order of reads and writes can be issued on consecutive edges with no idle cycle on the data bus.

Commands either load a new address or continue a burst. A continue step moves a 2-bit burst counter that follows one of two orders, linear or interleaved, chosen by a static mode input. A clock-enable input freezes the whole block. An asynchronous output enable gates the read driver. The bidirectional data bus is split into an input port, an output port and an active-high drive flag. Write data is held in a pending register until the next enabled edge commits it. Any read of a pending location receives the pending bytes merged into the stored word.

Top module: `ltwr_sram`

## Requirements
- R1: A write command, with its address and byte mask, is captured on an enabled rising edge. Its data is taken from `dataIn` on the next enabled rising edge, and later reads of that address return it.
- R2: A read command captured on an enabled edge drives the addressed word on `dataOut` with `dataDrive`=1 during the following cycle. Reads and writes may alternate on consecutive edges with no idle cycle.
- R3: A load (`advLd`=0) selects the device only when `ce0N`=0, `ce1`=1 and `ce2N`=0. Any other combination starts a deselect cycle, and `dataDrive` is 0.
- R4: When `advLd`=1, the `addr`, chip-enable and `rdWrN` inputs are ignored. The cycle repeats the type set at the start of the burst: read, write or deselect.
- R5: Each continue step increments a 2-bit counter that wraps every fourth step. The two low address bits are the start bits plus the count modulo 4 when `burstLinear`=1, or the start bits XOR the count when `burstLinear`=0. The upper bits stay fixed.
- R6: `byteWrN[0]` gates bits 8:0 and `byteWrN[1]` gates bits 17:9, both active low. They are sampled on every write cycle, including continues. A write with both bits high changes no stored bit.
- R7: A read cycle with `oeN`=1 leaves `dataDrive` at 0, but the cycle still takes place and the burst counter still advances.
- R8: `oeN` acts on `dataDrive` combinationally within a read cycle, with no clock edge needed.
- R9: `dataDrive` is 0 during every write cycle, whatever the level of `oeN`.
- R10: While `cenN`=1, rising edges change no state and commit no write. A read in progress keeps driving the same word, and a write in progress keeps the bus undriven.
- R11: A read issued on the edge right after a write to the same address returns the new bytes for the enabled lanes and the old bytes for the others.
- R12: A synchronous active-high `rst` discards the pending write and forces the deselect state, so `dataDrive` is 0. A continue step after reset stays deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cenN | input | 1 | Clock enable, active low; high stalls the block |
| ce0N | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2N | input | 1 | Chip enable, active low |
| advLd | input | 1 | 1 continues the burst, 0 loads a new command |
| rdWrN | input | 1 | On load: 1 read, 0 write |
| byteWrN | input | 2 | Byte write enables, active low; bit 0 lower byte |
| oeN | input | 1 | Asynchronous output enable, active low |
| burstLinear | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | 8 | Word address for a load |
| dataIn | input | 18 | Write data, one edge after the write command |
| dataOut | output | 18 | Read data |
| dataDrive | output | 1 | High when the block drives the data bus |

## Verification
A wrong cycle type or address shows on the ports in the cycle right after the edge that registers it. It appears as a `dataDrive` level that does not match the expected one, or as the wrong word on `dataOut`. A write that lands in the wrong lane or location, or is lost, shows later, on the first read of that address. When that read comes one edge after the write, it tests the forwarding path; when it comes several edges later, it tests the stored copy. A freeze fault under `cenN` shows as a changed output during the stalled cycle, or as the wrong write data reaching the array afterwards.

// File: rtl/ltwr_pkg.sv
package ltwr_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // this cycle is a write cycle and the edge ending it is enabled
    logic readCyc;  // this cycle is a read cycle
    logic stall;    // clock enable is inactive
  } strobe_t;

endpackage

// File: rtl/ltwr_burst_gen.sv
module ltwr_burst_gen #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              load,
  input  logic              linear,
  input  logic [ADDR_W-1:0] loadAddr,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] baseAddr;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lowBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseAddr <= '0;
      cnt      <= '0;
    end else if (enable) begin
      if (load) begin
        baseAddr <= loadAddr;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (linear) lowBits = baseAddr[CNT_W-1:0] + cnt;
    else        lowBits = baseAddr[CNT_W-1:0] ^ cnt;
    curAddr = {baseAddr[ADDR_W-1:CNT_W], lowBits};
  end

  assert_burst_step_R5: assert property (@(posedge clk) disable iff (rst)
    (enable && !load) |=> (cnt == $past(cnt) + 2'd1) && $stable(baseAddr));

  assert_burst_load_R5: assert property (@(posedge clk) disable iff (rst)
    (enable && load) |=> (cnt == '0) && (curAddr == $past(loadAddr)));

endmodule

// File: rtl/ltwr_ctrl.sv
module ltwr_ctrl
  import ltwr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cenN,
  input  logic              ce0N,
  input  logic              ce1,
  input  logic              ce2N,
  input  logic              advLd,
  input  logic              rdWrN,
  input  logic [BYTES-1:0]  byteWrN,
  input  logic              burstLinear,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strobes,
  output logic [ADDR_W-1:0] curAddr,
  output logic [BYTES-1:0]  curBe
);
  op_e  curOp;
  logic selected;
  logic stepEn;

  assign selected = !ce0N && ce1 && !ce2N;
  assign stepEn   = !cenN;

  ltwr_burst_gen #(.ADDR_W(ADDR_W)) burst_i (
    .clk      (clk),
    .rst      (rst),
    .enable   (stepEn),
    .load     (!advLd),
    .linear   (burstLinear),
    .loadAddr (addr),
    .curAddr  (curAddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      curOp <= OP_IDLE;
      curBe <= '0;
    end else if (stepEn) begin
      if (!advLd) begin
        if (!selected)  curOp <= OP_IDLE;
        else if (rdWrN) curOp <= OP_READ;
        else            curOp <= OP_WRITE;
      end
      curBe <= ~byteWrN;
    end
  end

  always_comb begin
    strobes.capture = (curOp == OP_WRITE) && stepEn;
    strobes.readCyc = (curOp == OP_READ);
    strobes.stall   = cenN;
  end

  assert_desel_load_R3: assert property (@(posedge clk) disable iff (rst)
    (!cenN && !advLd && !selected) |=> (curOp == OP_IDLE));

  assert_continue_type_R4: assert property (@(posedge clk) disable iff (rst)
    (!cenN && advLd) |=> (curOp == $past(curOp)));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    cenN |=> $stable(curOp) && $stable(curAddr) && $stable(curBe));

endmodule

// File: rtl/ltwr_datapath.sv
module ltwr_datapath
  import ltwr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9,
  parameter int BYTES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  strobe_t                 strobes,
  input  logic [ADDR_W-1:0]       curAddr,
  input  logic [BYTES-1:0]        curBe,
  input  logic                    oeN,
  input  logic [BYTE_W*BYTES-1:0] dataIn,
  output logic [BYTE_W*BYTES-1:0] dataOut,
  output logic                    dataDrive
);
  localparam int DATA_W = BYTE_W * BYTES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [BYTES-1:0]  pendBe;
  logic [DATA_W-1:0] pendData;
  logic [DATA_W-1:0] rdWord;
  logic              hitPend;

  assign hitPend = pendValid && (pendAddr == curAddr);

  // pending late-write register: filled when write data arrives
  always_ff @(posedge clk) begin
    if (rst) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendBe    <= '0;
      pendData  <= '0;
    end else if (!strobes.stall) begin
      pendValid <= strobes.capture && (|curBe);
      pendAddr  <= curAddr;
      pendBe    <= curBe;
      pendData  <= dataIn;
    end
  end

  // one storage lane per byte; commit on the next enabled edge
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic              useFwd;

    always_ff @(posedge clk) begin
      if (!rst && !strobes.stall && pendValid && pendBe[b])
        mem[pendAddr] <= pendData[b*BYTE_W +: BYTE_W];
    end

    assign useFwd = hitPend && pendBe[b];
    assign rdWord[b*BYTE_W +: BYTE_W] =
      useFwd ? pendData[b*BYTE_W +: BYTE_W] : mem[curAddr];
  end

  assign dataDrive = strobes.readCyc && !oeN;
  assign dataOut   = dataDrive ? rdWord : '0;

  assert_abort_no_pend_R6: assert property (@(posedge clk) disable iff (rst)
    (!strobes.stall && strobes.capture && (curBe == '0)) |=> !pendValid);

  assert_stall_pend_R10: assert property (@(posedge clk) disable iff (rst)
    strobes.stall |=> $stable(pendValid) && $stable(pendData) && $stable(pendAddr));

  assert_capture_data_R1: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && (|curBe)) |=> pendValid && (pendData == $past(dataIn)));

endmodule

// File: rtl/ltwr_sram.sv
module ltwr_sram
  import ltwr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9,
  parameter int BYTES  = 2,
  localparam int DATA_W = BYTE_W * BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cenN,
  input  logic              ce0N,
  input  logic              ce1,
  input  logic              ce2N,
  input  logic              advLd,
  input  logic              rdWrN,
  input  logic [BYTES-1:0]  byteWrN,
  input  logic              oeN,
  input  logic              burstLinear,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive
);
  strobe_t           strobes;
  logic [ADDR_W-1:0] curAddr;
  logic [BYTES-1:0]  curBe;

  ltwr_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .cenN        (cenN),
    .ce0N        (ce0N),
    .ce1         (ce1),
    .ce2N        (ce2N),
    .advLd       (advLd),
    .rdWrN       (rdWrN),
    .byteWrN     (byteWrN),
    .burstLinear (burstLinear),
    .addr        (addr),
    .strobes     (strobes),
    .curAddr     (curAddr),
    .curBe       (curBe)
  );

  ltwr_datapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BYTES(BYTES)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .curAddr   (curAddr),
    .curBe     (curBe),
    .oeN       (oeN),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .dataDrive (dataDrive)
  );

  assert_reset_quiet_R12: assert property (@(posedge clk)
    rst |=> !strobes.readCyc);

  assert_write_no_drive_R9: assert property (@(posedge clk) disable iff (rst)
    (!cenN && !advLd && !ce0N && ce1 && !ce2N && !rdWrN) |=> !dataDrive);

endmodule

// File: tb/ltwr_sram_tb_top.sv
`timescale 1ns/1ps
module ltwr_sram_tb_top;
  localparam logic [2:0] SEL = 3'b010; // {ce0N, ce1, ce2N}

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cenN = 1'b0, ce0N = 1'b1, ce1 = 1'b0, ce2N = 1'b1;
  logic        advLd = 1'b0, rdWrN = 1'b1, oeN = 1'b0, burstLinear = 1'b1;
  logic [1:0]  byteWrN = 2'b11;
  logic [7:0]  addr = '0;
  logic [17:0] dataIn = '0;
  logic [17:0] dataOut;
  logic        dataDrive;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  logic [17:0] mMem [256];
  int          mOp = 0;        // 0 idle, 1 read, 2 write
  logic [7:0]  mBase = '0;
  logic [1:0]  mCnt = '0;
  logic [1:0]  mBe = '0;
  bit          autoWd = 0;

  always #4 clk = ~clk;

  ltwr_sram dut_i (
    .clk(clk), .rst(rst), .cenN(cenN), .ce0N(ce0N), .ce1(ce1), .ce2N(ce2N),
    .advLd(advLd), .rdWrN(rdWrN), .byteWrN(byteWrN), .oeN(oeN),
    .burstLinear(burstLinear), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

  function automatic logic [7:0] expAddr(logic [7:0] base, logic [1:0] cnt, logic lin);
    logic [1:0] lo;
    lo = lin ? (base[1:0] + cnt) : (base[1:0] ^ cnt);
    return {base[7:2], lo};
  endfunction

  function automatic logic [17:0] pat(logic [7:0] a);
    return 18'((a * 18'h0123) ^ 18'h2A5C1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkBus(input string tag);
    logic expD;
    logic [17:0] expW;
    expD = (mOp == 1) && !oeN;
    chk(dataDrive === expD, tag, 18'(dataDrive), 18'(expD));
    if (expD) begin
      expW = mMem[expAddr(mBase, mCnt, burstLinear)];
      chk(dataOut === expW, tag, dataOut, expW);
    end
  endtask

  task automatic step(input logic cen, input logic adv, input logic [2:0] ce,
                      input logic rw, input logic [1:0] bwN, input logic oe,
                      input logic [7:0] a, input logic [17:0] wd, input string tag);
    logic [7:0]  cur;
    logic [17:0] w;
    @(negedge clk);
    cur = expAddr(mBase, mCnt, burstLinear);
    w = (autoWd && mOp == 2) ? pat(cur) : wd;
    cenN = cen; advLd = adv; {ce0N, ce1, ce2N} = ce; rdWrN = rw;
    byteWrN = bwN; oeN = oe; addr = a; dataIn = w;
    @(posedge clk);
    if (!cen) begin
      if (mOp == 2) begin
        if (mBe[0]) mMem[cur][8:0]  = w[8:0];
        if (mBe[1]) mMem[cur][17:9] = w[17:9];
      end
      if (!adv) begin
        mOp = (ce == SEL) ? (rw ? 1 : 2) : 0;
        mBase = a;
        mCnt = '0;
      end else begin
        mCnt = mCnt + 2'd1;
      end
      mBe = ~bwN;
    end
    #1;
    checkBus(tag);
  endtask

  task automatic midReset();
    @(negedge clk);
    rst = 1'b1; cenN = 1'b0; advLd = 1'b1;
    @(posedge clk);
    #1;
    mOp = 0;
    chk(dataDrive === 1'b0, "R12 reset", 18'(dataDrive), 18'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(dataDrive === 1'b0, "R12 initial", 18'(dataDrive), 18'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1: preload all words with linear write bursts
    autoWd = 1;
    burstLinear = 1'b1;
    for (int b = 0; b < 64; b++) begin
      step(0, 0, SEL, 0, 2'b00, 0, 8'(b * 4), '0, "R1 load");
      for (int k = 0; k < 3; k++) step(0, 1, SEL, 0, 2'b00, 0, '0, '0, "R1 burst");
    end
    autoWd = 0;
    step(0, 0, 3'b110, 1, 2'b11, 0, '0, '0, "R3 desel"); // delivers last data
    step(0, 0, SEL, 1, 2'b11, 0, 8'h9B, '0, "R1 readback");
    chk(dataOut === pat(8'h9B), "R1 preload", dataOut, pat(8'h9B));

    // R2/R11: back-to-back writes and reads, forwarding
    step(0, 0, SEL, 0, 2'b00, 0, 8'h10, '0, "R2 write");
    step(0, 0, SEL, 1, 2'b11, 0, 8'h10, 18'h0ABCD, "R11 fwd read");
    chk(dataOut === 18'h0ABCD, "R11 full word", dataOut, 18'h0ABCD);
    step(0, 0, SEL, 0, 2'b10, 0, 8'h11, '0, "R6 lower lane write");
    step(0, 0, SEL, 1, 2'b11, 0, 8'h11, 18'h3FFFF, "R11 merged read");
    chk(dataOut === {pat(8'h11)[17:9], 9'h1FF}, "R11 merge", dataOut, {pat(8'h11)[17:9], 9'h1FF});
    step(0, 0, SEL, 0, 2'b11, 0, 8'h12, '0, "R6 abort");
    step(0, 0, SEL, 1, 2'b11, 0, 8'h12, 18'h12345, "R6 abort read");
    chk(dataOut === pat(8'h12), "R6 abort unchanged", dataOut, pat(8'h12));
    step(0, 0, SEL, 0, 2'b01, 0, 8'h13, '0, "R9 write oe low");
    chk(dataDrive === 1'b0, "R9 no drive", 18'(dataDrive), 18'd0);
    step(0, 0, SEL, 1, 2'b11, 0, 8'h13, 18'h2AAAA, "R6 upper lane read");
    chk(dataOut === {9'h155, pat(8'h13)[8:0]}, "R6 upper lane", dataOut, {9'h155, pat(8'h13)[8:0]});

    // R5: interleaved read burst from 0x21 wraps after four steps
    burstLinear = 1'b0;
    step(0, 0, SEL, 1, 2'b11, 0, 8'h21, '0, "R5 il start");
    for (int k = 0; k < 4; k++) step(0, 1, 3'b111, 0, 2'b00, 0, 8'hEE, '0, "R4 R5 il continue");
    chk(dataOut === pat(8'h21), "R5 wrap", dataOut, pat(8'h21));
    // R5: linear read burst from 0x31
    burstLinear = 1'b1;
    step(0, 0, SEL, 1, 2'b11, 0, 8'h31, '0, "R5 lin start");
    step(0, 1, SEL, 0, 2'b00, 0, 8'h00, '0, "R5 lin +1");
    chk(dataOut === pat(8'h32), "R5 linear", dataOut, pat(8'h32));
    step(0, 1, SEL, 1, 2'b11, 0, 8'h00, '0, "R5 lin +2");
    step(0, 1, SEL, 1, 2'b11, 0, 8'h00, '0, "R5 lin +3");
    chk(dataOut === pat(8'h30), "R5 linear wrap", dataOut, pat(8'h30));

    // R7: dummy read still advances
    step(0, 0, SEL, 1, 2'b11, 1, 8'h40, '0, "R7 dummy");
    chk(dataDrive === 1'b0, "R7 dummy quiet", 18'(dataDrive), 18'd0);
    step(0, 1, SEL, 1, 2'b11, 0, 8'h00, '0, "R7 advanced");
    chk(dataOut === pat(8'h41), "R7 advanced", dataOut, pat(8'h41));

    // R8: asynchronous output enable
    step(0, 0, SEL, 1, 2'b11, 0, 8'h05, '0, "R8 read");
    oeN = 1'b1; #1;
    chk(dataDrive === 1'b0, "R8 oe off", 18'(dataDrive), 18'd0);
    oeN = 1'b0; #1;
    chk(dataDrive === 1'b1, "R8 oe on", 18'(dataDrive), 18'd1);

    // R10: stalls
    step(0, 0, SEL, 1, 2'b11, 0, 8'h06, '0, "R10 read");
    step(1, 0, SEL, 0, 2'b00, 0, 8'h77, '0, "R10 read stall");
    chk(dataOut === pat(8'h06), "R10 hold data", dataOut, pat(8'h06));
    step(0, 0, SEL, 0, 2'b00, 0, 8'h07, '0, "R10 write");
    step(1, 0, SEL, 1, 2'b11, 0, 8'h07, 18'h3FFFF, "R10 write stall");
    step(1, 0, SEL, 1, 2'b11, 0, 8'h07, 18'h3FFFF, "R10 write stall");
    step(0, 0, SEL, 1, 2'b11, 0, 8'h07, 18'h15555, "R10 resume");
    chk(dataOut === 18'h15555, "R10 stall data", dataOut, 18'h15555);

    // R3: each deselect combination, then continue deselect
    step(0, 0, 3'b110, 1, 2'b11, 0, 8'h05, '0, "R3 ce0 high");
    step(0, 0, 3'b011, 1, 2'b11, 0, 8'h05, '0, "R3 ce2 high");
    step(0, 0, 3'b000, 1, 2'b11, 0, 8'h05, '0, "R3 ce1 low");
    step(0, 1, SEL, 1, 2'b11, 0, 8'h05, '0, "R4 continue desel");

    // R12: reset during a read burst
    step(0, 0, SEL, 1, 2'b11, 0, 8'h50, '0, "R12 pre read");
    step(0, 1, SEL, 1, 2'b11, 0, 8'h00, '0, "R12 pre burst");
    midReset();
    step(0, 1, SEL, 1, 2'b11, 0, 8'h00, '0, "R12 continue after reset");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] ce;
      logic [7:0] a;
      if (i == 300) burstLinear = 1'b0;
      ce = ($urandom % 5 == 0) ? 3'($urandom) : SEL;
      a = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 16);
      step(($urandom % 10) == 0, ($urandom % 3) == 0, ce, 1'($urandom),
           2'($urandom), ($urandom % 6) == 0, a, 18'($urandom), "R2 R11 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule